// File: doc/BRIEF.md
# Core Debug Halt and Instruction-Inject Port

This block gives a host processor control over a small RISC-V core through a byte-wide register window of eight offsets. From this window the host can hold the core in reset or stop it. Writes to a set register and a separate clear register raise and drop these controls, so there is no read-modify-write. The window also shows whether the core stopped itself on a breakpoint. The host can turn on single stepping, in which the core is stopped again after every instruction it retires.

While the core is stopped and ready, the host builds a 32-bit instruction one byte at a time and issues it by writing the top byte. The same four offsets, when read, return the value that the most recently executed instruction wrote back. This holds even when the destination was register zero, so an instruction that moves any register into x0 can be used to read that register's contents.

Top module: `core_dbg_port`

## Requirements
- R1: After rst_ni is released, reset_o, halt_o and inject_valid_o are 0, and every offset from 0 to 7 reads 0 while inject_busy_i is 0.
- R2: A host write to offset 2 with data bit 0 set turns reset_o on. The same write with data bit 1 set turns the forced halt on. Zero data bits change nothing.
- R3: A host write to offset 3 with data bit 0 set turns reset_o off. The same write with data bit 1 set clears both the forced halt and the breakpoint halt. Zero data bits change nothing.
- R4: Offset 0 reads {3'b0, step, brk, inject_busy_i, halt, reset} (bit 4 down to bit 0). A write to offset 0 changes only the step bit, which takes data bit 4. Offset 1 always reads 0.
- R5: ebreak_i sets the breakpoint flag (offset 0 bit 3) one cycle later, provided reset is not forced. halt_o is the OR of the forced halt and the breakpoint flag.
- R6: When step mode is on, retire_i sets the forced halt on the next cycle. If a write to offset 3 tries to clear the halt in the same cycle, the set wins.
- R7: Offsets 4 to 7 hold instruction bytes 0 to 3, least significant first. A write to offset 7 drives inject_valid_o high for exactly one cycle, starting one cycle after the write. inject_instr_o then carries the written top byte together with the three stored lower bytes.
- R8: The core accepts an issue only if halt_o is 1 and inject_busy_i is 0 in the cycle of the offset 7 write. In any other case the write raises no inject_valid_o and leaves inject_instr_o unchanged.
- R9: When wb_valid_i is high, wb_data_i is captured. From the next cycle on, reads of offsets 4 to 7 return the captured value, least significant byte first.
- R10: While reset is forced, the breakpoint flag is held at 0 and ebreak_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 3 | Host register offset |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for host_addr_i (combinational) |
| reset_o | output | 1 | Holds the core in reset |
| halt_o | output | 1 | Holds the core stopped |
| inject_valid_o | output | 1 | One-cycle issue strobe for an injected instruction |
| inject_instr_o | output | 32 | Injected instruction |
| inject_busy_i | input | 1 | Core cannot take an injected instruction |
| retire_i | input | 1 | Core retired one instruction |
| ebreak_i | input | 1 | Core executed a breakpoint instruction |
| wb_valid_i | input | 1 | Core write-back valid |
| wb_data_i | input | 32 | Core write-back value |

## Verification
Every register update, whether from a host write, a step retire, a breakpoint or a write-back capture, shows up on the clock edge that samples the stimulus. The inject strobe is registered and appears at that same edge. Host reads are combinational. Each bench operation therefore drives its inputs at a falling edge, lets one rising edge go by, and then samples at the next falling edge. At that point it compares inject_valid_o, inject_instr_o, reset_o, halt_o and the offset 0 read against a model that was advanced for exactly that one edge.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;
  localparam int unsigned OFF_STATUS = 0;
  localparam int unsigned OFF_SET    = 2;
  localparam int unsigned OFF_CLR    = 3;
  localparam int unsigned B_RST  = 0;
  localparam int unsigned B_HALT = 1;
  localparam int unsigned B_BUSY = 2;
  localparam int unsigned B_BRK  = 3;
  localparam int unsigned B_STEP = 4;
endpackage

// File: rtl/dbg_ctrl_state.sv
module dbg_ctrl_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_rst_i,
  input  logic clr_rst_i,
  input  logic set_halt_i,
  input  logic clr_halt_i,
  input  logic step_we_i,
  input  logic step_d_i,
  input  logic retire_i,
  input  logic ebreak_i,
  output logic reset_q_o,
  output logic halt_q_o,
  output logic brk_q_o,
  output logic step_q_o
);
  logic reset_q, halt_q, brk_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_q <= 1'b0;
      halt_q  <= 1'b0;
      brk_q   <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      if (set_rst_i)      reset_q <= 1'b1;
      else if (clr_rst_i) reset_q <= 1'b0;
      // step retire re-halts even against a concurrent clear
      if (set_halt_i || (step_q && retire_i)) halt_q <= 1'b1;
      else if (clr_halt_i)                    halt_q <= 1'b0;
      if (reset_q)         brk_q <= 1'b0;
      else if (ebreak_i)   brk_q <= 1'b1;
      else if (clr_halt_i) brk_q <= 1'b0;
      if (step_we_i) step_q <= step_d_i;
    end
  end

  assign reset_q_o = reset_q;
  assign halt_q_o  = halt_q;
  assign brk_q_o   = brk_q;
  assign step_q_o  = step_q;
endmodule

// File: rtl/dbg_inject.sv
module dbg_inject #(
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [$clog2(NB)-1:0] sel_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  allow_i,
  output logic                  valid_o,
  output logic [NB*DW-1:0]      instr_o
);
  localparam int unsigned SW = $clog2(NB);

  logic [NB-2:0][DW-1:0] stage_q;
  logic [NB*DW-1:0]      instr_q;
  logic                  valid_q;
  logic                  fire;

  assign fire = wr_i && (sel_i == SW'(NB-1));

  for (genvar b = 0; b < NB-1; b++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          stage_q[b] <= '0;
      else if (wr_i && (sel_i == SW'(b)))   stage_q[b] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      instr_q <= '0;
    end else begin
      valid_q <= fire && allow_i;
      if (fire && allow_i) instr_q <= {wdata_i, stage_q};
    end
  end

  assign valid_o = valid_q;
  assign instr_o = instr_q;
endmodule

// File: rtl/dbg_readback.sv
module dbg_readback #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wb_valid_i,
  input  logic [W-1:0] wb_data_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         value_q <= '0;
    else if (wb_valid_i) value_q <= wb_data_i;
  end

  assign value_o = value_q;
endmodule

// File: rtl/core_dbg_port.sv
module core_dbg_port #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 32,
  localparam int unsigned NB  = IW / DW,
  localparam int unsigned BSW = $clog2(NB),
  localparam int unsigned AW  = BSW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_wr_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          reset_o,
  output logic          halt_o,
  output logic          inject_valid_o,
  output logic [IW-1:0] inject_instr_o,
  input  logic          inject_busy_i,
  input  logic          retire_i,
  input  logic          ebreak_i,
  input  logic          wb_valid_i,
  input  logic [IW-1:0] wb_data_i
);
  import dbg_port_pkg::*;

  logic wr_status, wr_set, wr_clr, wr_instr;
  logic reset_q, halt_q, brk_q, step_q;
  logic [NB-1:0][DW-1:0] rb_bytes;
  logic [IW-1:0] rb_value;

  assign wr_status = host_wr_i && (host_addr_i == AW'(OFF_STATUS));
  assign wr_set    = host_wr_i && (host_addr_i == AW'(OFF_SET));
  assign wr_clr    = host_wr_i && (host_addr_i == AW'(OFF_CLR));
  assign wr_instr  = host_wr_i && host_addr_i[AW-1];

  dbg_ctrl_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_rst_i  (wr_set && host_wdata_i[0]),
    .clr_rst_i  (wr_clr && host_wdata_i[0]),
    .set_halt_i (wr_set && host_wdata_i[1]),
    .clr_halt_i (wr_clr && host_wdata_i[1]),
    .step_we_i  (wr_status),
    .step_d_i   (host_wdata_i[B_STEP]),
    .retire_i   (retire_i),
    .ebreak_i   (ebreak_i),
    .reset_q_o  (reset_q),
    .halt_q_o   (halt_q),
    .brk_q_o    (brk_q),
    .step_q_o   (step_q)
  );

  assign reset_o = reset_q;
  assign halt_o  = halt_q | brk_q;

  dbg_inject #(.DW(DW), .NB(NB)) u_inject (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_instr),
    .sel_i   (host_addr_i[BSW-1:0]),
    .wdata_i (host_wdata_i),
    .allow_i (halt_o && !inject_busy_i),
    .valid_o (inject_valid_o),
    .instr_o (inject_instr_o)
  );

  dbg_readback #(.W(IW)) u_readback (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wb_valid_i (wb_valid_i),
    .wb_data_i  (wb_data_i),
    .value_o    (rb_value)
  );

  assign rb_bytes = rb_value;

  always_comb begin
    host_rdata_o = '0;
    if (host_addr_i[AW-1]) begin
      host_rdata_o = rb_bytes[host_addr_i[BSW-1:0]];
    end else if (host_addr_i == AW'(OFF_STATUS)) begin
      host_rdata_o[B_RST]  = reset_q;
      host_rdata_o[B_HALT] = halt_q;
      host_rdata_o[B_BUSY] = inject_busy_i;
      host_rdata_o[B_BRK]  = brk_q;
      host_rdata_o[B_STEP] = step_q;
    end
  end
endmodule

// File: rtl/core_dbg_port_chk.sv
module core_dbg_port_chk #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_wr_i,
  input logic [AW-1:0] host_addr_i,
  input logic [DW-1:0] host_wdata_i,
  input logic          reset_o,
  input logic          halt_o,
  input logic          inject_valid_o,
  input logic          inject_busy_i,
  input logic          retire_i,
  input logic          ebreak_i,
  input logic          halt_q,
  input logic          brk_q,
  input logic          step_q
);
  a_r2_set_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_addr_i == AW'(2) && host_wdata_i[0] |=> reset_o);

  a_r3_clr_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_addr_i == AW'(3) && host_wdata_i[0] |=> !reset_o);

  a_r3_clr_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_addr_i == AW'(3) && host_wdata_i[1] && !ebreak_i |=> !brk_q);

  a_r5_brk_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ebreak_i && !reset_o |=> halt_o);

  a_r6_step_rehalt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q && retire_i |=> halt_q);

  a_r7_fire_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_valid_o |-> $past(host_wr_i && host_addr_i == {AW{1'b1}}));

  a_r8_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_valid_o |-> $past(halt_o && !inject_busy_i));

  a_r10_rst_clears_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |=> !brk_q);
endmodule

bind core_dbg_port core_dbg_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .host_wr_i      (host_wr_i),
  .host_addr_i    (host_addr_i),
  .host_wdata_i   (host_wdata_i),
  .reset_o        (reset_o),
  .halt_o         (halt_o),
  .inject_valid_o (inject_valid_o),
  .inject_busy_i  (inject_busy_i),
  .retire_i       (retire_i),
  .ebreak_i       (ebreak_i),
  .halt_q         (halt_q),
  .brk_q          (brk_q),
  .step_q         (step_q)
);

// File: tb/core_dbg_port_bench.sv
`timescale 1ns/1ps
module core_dbg_port_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr_i = 1'b0;
  logic [2:0]  host_addr_i = '0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;
  logic        reset_o, halt_o, inject_valid_o;
  logic [31:0] inject_instr_o;
  logic        inject_busy_i = 1'b0;
  logic        retire_i = 1'b0;
  logic        ebreak_i = 1'b0;
  logic        wb_valid_i = 1'b0;
  logic [31:0] wb_data_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic m_rst = 0, m_halt = 0, m_brk = 0, m_step = 0;
  logic [31:0] m_rb = '0;
  logic [7:0]  m_byte [0:2];
  logic [31:0] m_instr = '0;

  always #4 clk_i = ~clk_i;

  core_dbg_port u_core_dbg_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o), .reset_o(reset_o),
    .halt_o(halt_o), .inject_valid_o(inject_valid_o), .inject_instr_o(inject_instr_o),
    .inject_busy_i(inject_busy_i), .retire_i(retire_i), .ebreak_i(ebreak_i),
    .wb_valid_i(wb_valid_i), .wb_data_i(wb_data_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {3'b000, m_step, m_brk, inject_busy_i, m_halt, m_rst};
  endfunction

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr_i = a;
    #1 d = host_rdata_o;
  endtask

  // one clock: drive at negedge, advance model at posedge, check at next negedge
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d,
                     input logic eb, input logic ret, input logic wbv,
                     input logic [31:0] wbd, input logic busy, input string tag);
    logic exp_v;
    logic sr, cr, sh, ch;
    logic n_rst, n_halt, n_brk;
    logic [7:0] st;
    host_wr_i = wr; host_addr_i = a; host_wdata_i = d;
    ebreak_i = eb; retire_i = ret; wb_valid_i = wbv; wb_data_i = wbd; inject_busy_i = busy;
    exp_v = wr && a == 3'd7 && (m_halt || m_brk) && !busy;
    if (exp_v) m_instr = {d, m_byte[2], m_byte[1], m_byte[0]};
    sr = wr && a == 3'd2 && d[0]; sh = wr && a == 3'd2 && d[1];
    cr = wr && a == 3'd3 && d[0]; ch = wr && a == 3'd3 && d[1];
    n_rst  = sr ? 1'b1 : (cr ? 1'b0 : m_rst);
    n_halt = (sh || (m_step && ret)) ? 1'b1 : (ch ? 1'b0 : m_halt);
    n_brk  = m_rst ? 1'b0 : (eb ? 1'b1 : (ch ? 1'b0 : m_brk));
    @(posedge clk_i);
    m_rst = n_rst; m_halt = n_halt; m_brk = n_brk;
    if (wr && a == 3'd0) m_step = d[4];
    if (wr && a >= 3'd4 && a <= 3'd6) m_byte[a - 3'd4] = d;
    if (wbv) m_rb = wbd;
    @(negedge clk_i);
    host_wr_i = 0; ebreak_i = 0; retire_i = 0; wb_valid_i = 0;
    chk({tag, " R7/R8 valid"}, 32'(inject_valid_o), 32'(exp_v));
    chk({tag, " R7/R8 instr"}, inject_instr_o, m_instr);
    chk({tag, " R2/R3 reset_o"}, 32'(reset_o), 32'(m_rst));
    chk({tag, " R5 halt_o"}, 32'(halt_o), 32'(m_halt | m_brk));
    rd(3'd0, st);
    chk({tag, " R4 status"}, 32'(st), 32'(exp_status()));
  endtask

  task automatic check_rb(input string tag);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), b);
      chk(tag, 32'(b), 32'(m_rb[i*8 +: 8]));
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) m_byte[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 reset_o", 32'(reset_o), 0);
    chk("R1 halt_o", 32'(halt_o), 0);
    chk("R1 inject_valid_o", 32'(inject_valid_o), 0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), b);
      chk("R1 read zero", 32'(b), 0);
    end
    // R2 set reset, R10 ebreak ignored under reset
    cyc(1, 3'd2, 8'h01, 0, 0, 0, 0, 0, "R2 set reset");
    chk("R2 reset_o on", 32'(reset_o), 1);
    cyc(0, 3'd0, 8'h00, 1, 0, 0, 0, 0, "R10 ebreak in reset");
    rd(3'd0, b);
    chk("R10 brk held low", 32'(b[3]), 0);
    chk("R10 halt_o low", 32'(halt_o), 0);
    cyc(1, 3'd3, 8'h01, 0, 0, 0, 0, 0, "R3 clear reset");
    chk("R3 reset_o off", 32'(reset_o), 0);
    // zero bits have no effect
    cyc(1, 3'd2, 8'hFC, 0, 0, 0, 0, 0, "R2 zero bits");
    rd(3'd0, b);
    chk("R2 zero bits no effect", 32'(b), 0);
    // R4 only step writable, offset 1 zero
    cyc(1, 3'd0, 8'hEF, 0, 0, 0, 0, 0, "R4 write status");
    rd(3'd0, b);
    chk("R4 step not set by other bits", 32'(b), 0);
    cyc(1, 3'd0, 8'hFF, 0, 0, 0, 0, 0, "R4 write step");
    rd(3'd0, b);
    chk("R4 only step writable", 32'(b), 32'h10);
    cyc(1, 3'd1, 8'hFF, 0, 0, 0, 0, 0, "R4 write off1");
    rd(3'd1, b);
    chk("R4 offset1 zero", 32'(b), 0);
    cyc(1, 3'd0, 8'h00, 0, 0, 0, 0, 0, "R4 step off");
    // R8 not halted: dropped
    cyc(1, 3'd7, 8'hAA, 0, 0, 0, 0, 0, "R8 not halted");
    chk("R8 dropped when running", 32'(inject_valid_o), 0);
    // R5 breakpoint
    cyc(0, 3'd0, 8'h00, 1, 0, 0, 0, 0, "R5 ebreak");
    rd(3'd0, b);
    chk("R5 status brk", 32'(b), 32'h08);
    chk("R5 halt_o", 32'(halt_o), 1);
    // R7 inject
    cyc(1, 3'd4, 8'h13, 0, 0, 0, 0, 0, "R7 b0");
    cyc(1, 3'd5, 8'h05, 0, 0, 0, 0, 0, "R7 b1");
    cyc(1, 3'd6, 8'h10, 0, 0, 0, 0, 0, "R7 b2");
    cyc(1, 3'd7, 8'h00, 0, 0, 0, 0, 0, "R7 b3");
    chk("R7 valid", 32'(inject_valid_o), 1);
    chk("R7 instr", inject_instr_o, 32'h00100513);
    cyc(0, 3'd0, 8'h00, 0, 0, 0, 0, 0, "R7 pulse end");
    chk("R7 one-cycle pulse", 32'(inject_valid_o), 0);
    // R8 busy: dropped, instr unchanged
    cyc(1, 3'd7, 8'h77, 0, 0, 0, 0, 1, "R8 busy");
    chk("R8 dropped when busy", 32'(inject_valid_o), 0);
    chk("R8 instr unchanged", inject_instr_o, 32'h00100513);
    // R3 clear halt clears brk
    cyc(1, 3'd3, 8'h02, 0, 0, 0, 0, 0, "R3 clear halt");
    chk("R3 halt_o off", 32'(halt_o), 0);
    // R6 stepping
    cyc(1, 3'd0, 8'h10, 0, 0, 0, 0, 0, "R6 step on");
    cyc(0, 3'd0, 8'h00, 0, 1, 0, 0, 0, "R6 retire");
    chk("R6 halt after retire", 32'(halt_o), 1);
    cyc(1, 3'd3, 8'h02, 0, 1, 0, 0, 0, "R6 clear vs retire");
    chk("R6 set wins", 32'(halt_o), 1);
    // R9 readback
    cyc(0, 3'd0, 8'h00, 0, 0, 1, 32'hDEADBEEF, 0, "R9 capture");
    check_rb("R9 readback bytes");
    cyc(1, 3'd0, 8'h00, 0, 0, 0, 0, 0, "R6 step off");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[3:1], r[11:4], r[14:12] == 0, r[16:15] == 0, r[18:17] == 0,
          $urandom, r[20:19] == 0, "rand");
      if (r[23:21] == 0) check_rb("R9 random readback");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule